// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

A local countdown timer that counts prescaled ticks of the system clock and requests an edge-type interrupt when a countdown ends. Software-facing logic (outside this block) drives three write strobes with a shared data word: one loads the start count, one programs the prescaler, and one writes a control word that picks one-shot or periodic operation, masks the interrupt and carries an 8-bit vector. The live count and all stored registers are visible on read ports at all times.

The prescaler divides the clock by a power of two picked by a 3-bit code spread over bits 3, 1 and 0 of the prescaler register. Writing the start count restarts both the countdown and the prescaler. A countdown from N lasts N+1 prescaled ticks: the count walks N, N-1, ... 0, and the tick after reaching 0 ends the period. In periodic mode the count then reloads to N. In one-shot mode it stays at 0. When the timer is not masked, the end of a period gives a one-cycle pulse together with the vector.

Top module: `dctimer`

## Requirements
- R1: After reset, count_now, load_val and prediv_val read 0, ctl_val reads 0x00010000 (masked), irq_fire is 0 and irq_vec is 0.
- R2: A prescaler write keeps only bits 3, 1 and 0 of wdata. prediv_val returns wdata & 0xB and all other bits read 0.
- R3: A control write keeps bit 17 (1 = periodic, 0 = one-shot), bit 16 (1 = interrupt masked) and bits 7:0 (vector). All other bits of ctl_val read 0.
- R4: The prescaler code is v = {bit3, bit1, bit0} and the divisor is 2^((v+1) mod 8), so code 7 divides by 1 and code 6 divides by 128. Between load writes the count changes only on a tick. Ticks come every divisor clocks, and the first one comes exactly divisor clocks after the load write.
- R5: A load write sets count_now to wdata one cycle later and restarts the prescaler phase, including while a countdown is already running.
- R6: In one-shot mode the count decreases by one per tick down to 0 and then holds at 0.
- R7: In one-shot mode with start count N and divisor D, an unmasked timer pulses irq_fire exactly once, in the cycle after clock (N+1)*D counted from the load write.
- R8: In periodic mode the count reloads to N on tick N+1, and an unmasked timer pulses every (N+1)*D clocks.
- R9: While masked, no pulse is produced but the count still runs. A one-shot end that occurs while masked is used up, so unmasking afterwards gives no pulse.
- R10: Each end of a period gives a one-cycle pulse. irq_vec carries control bits 7:0 during the pulse and is 0 in all other cycles.
- R11: Before the first load write after reset, the timer is idle: no pulse is produced even when unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_wr | input | 1 | Strobe: write the start count from wdata |
| prediv_wr | input | 1 | Strobe: write the prescaler code from wdata |
| ctl_wr | input | 1 | Strobe: write the control word from wdata |
| wdata | input | 32 | Write data shared by the three strobes |
| count_now | output | 32 | Live countdown value |
| load_val | output | 32 | Stored start count |
| prediv_val | output | 4 | Stored prescaler code bits |
| ctl_val | output | 32 | Stored control word (mode, mask, vector) |
| irq_fire | output | 1 | One-cycle interrupt request pulse |
| irq_vec | output | 8 | Vector that goes with the pulse, 0 otherwise |

## Verification
Register read ports and count_now show a write one cycle after the strobe edge, and the bench samples them at the next falling edge. A decrement appears one cycle after the tick edge. For start count N and divisor D, the pulse is due in the cycle after edge (N+1)*D counted from the load edge. The bench counts falling edges from the load write and checks that no pulse comes one cycle early, that the pulse comes in the expected cycle, and that the output is low again one cycle later. For periodic rows it also checks the second pulse at twice that distance.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // Control word field positions (decoded by the timer core)
  localparam int CTL_PERIODIC_BIT = 17;
  localparam int CTL_MASK_BIT     = 16;

  // Prescaler code width and raw register width
  localparam int PSC_CODE_W = 3;
  localparam int PSC_RAW_W  = 4;
  localparam logic [PSC_RAW_W-1:0] PSC_KEEP = 4'b1011;

  typedef enum logic {
    MODE_ONESHOT  = 1'b0,
    MODE_PERIODIC = 1'b1
  } mode_e;

  // Scattered code {b3,b1,b0} -> shift amount (code+1) mod 8
  function automatic logic [PSC_CODE_W-1:0] psc_shift(input logic [PSC_RAW_W-1:0] raw);
    logic [PSC_CODE_W-1:0] code;
    code = {raw[3], raw[1], raw[0]};
    return code + 3'd1;
  endfunction

endpackage

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_wr,
  input  logic                 prediv_wr,
  input  logic                 ctl_wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    load_q,
  output logic [PSC_RAW_W-1:0] prediv_q,
  output mode_e                mode_q,
  output logic                 mask_q,
  output logic [VEC_W-1:0]     vec_q
);

  logic [DATA_W-1:0]    load_d;
  logic [PSC_RAW_W-1:0] prediv_d;
  mode_e                mode_d;
  logic                 mask_d;
  logic [VEC_W-1:0]     vec_d;

  // Next-state with explicit enables
  always_comb begin
    load_d   = load_q;
    prediv_d = prediv_q;
    mode_d   = mode_q;
    mask_d   = mask_q;
    vec_d    = vec_q;
    if (load_wr) begin
      load_d = wdata;
    end
    if (prediv_wr) begin
      prediv_d = wdata[PSC_RAW_W-1:0] & PSC_KEEP;
    end
    if (ctl_wr) begin
      mode_d = mode_e'(wdata[CTL_PERIODIC_BIT]);
      mask_d = wdata[CTL_MASK_BIT];
      vec_d  = wdata[VEC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '0;
      prediv_q <= '0;
      mode_q   <= MODE_ONESHOT;
      mask_q   <= 1'b1;
      vec_q    <= '0;
    end else begin
      load_q   <= load_d;
      prediv_q <= prediv_d;
      mode_q   <= mode_d;
      mask_q   <= mask_d;
      vec_q    <= vec_d;
    end
  end

  // Bits outside the kept code never appear in the prescaler register
  assert_prediv_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prediv_q[2] == 1'b0);

endmodule

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic [PRE_W-1:0] sel;

  // Bits of the phase counter that take part in the divide
  for (genvar i = 0; i < PRE_W; i++) begin : g_sel
    assign sel[i] = (shift > SHIFT_W'(i));
  end

  // A tick when every selected phase bit is one
  assign tick = &(cnt_q | ~sel);

  always_comb begin
    if (clear) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assert_phase_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/dct_counter.sv
module dct_counter
  import dct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] reload,
  input  logic              tick,
  input  mode_e             mode,
  input  logic              masked,
  input  logic [VEC_W-1:0]  vec,
  output logic [DATA_W-1:0] count_q,
  output logic              fire_q,
  output logic [VEC_W-1:0]  fire_vec_q
);

  logic [DATA_W-1:0] count_d;
  logic              armed_q;
  logic              armed_d;
  logic              expire;
  logic              fire_d;
  logic [VEC_W-1:0]  fire_vec_d;

  always_comb begin
    count_d = count_q;
    armed_d = armed_q;
    expire  = 1'b0;
    if (load) begin
      count_d = load_data;
      armed_d = 1'b1;
    end else if (tick && armed_q) begin
      if (count_q != '0) begin
        count_d = count_q - DATA_W'(1);
      end else begin
        expire = 1'b1;
        if (mode == MODE_PERIODIC) begin
          count_d = reload;
        end else begin
          armed_d = 1'b0;
        end
      end
    end
    fire_d     = expire && !masked;
    fire_vec_d = fire_d ? vec : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      armed_q    <= 1'b0;
      fire_q     <= 1'b0;
      fire_vec_q <= '0;
    end else begin
      count_q    <= count_d;
      armed_q    <= armed_d;
      fire_q     <= fire_d;
      fire_vec_q <= fire_vec_d;
    end
  end

  assert_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(count_q));

  assert_oneshot_rests_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && mode == MODE_ONESHOT && count_q == '0) |=> (count_q == '0));

  assert_fire_follows_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(tick));

  assert_masked_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> !$past(masked));

  assert_vec_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_q |-> (fire_vec_q == '0));

  assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(armed_q));

endmodule

// File: rtl/dctimer.sv
module dctimer
  import dct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic              prediv_wr,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count_now,
  output logic [DATA_W-1:0] load_val,
  output logic [3:0]        prediv_val,
  output logic [DATA_W-1:0] ctl_val,
  output logic              irq_fire,
  output logic [VEC_W-1:0]  irq_vec
);

  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic [PSC_RAW_W-1:0]  prediv_q;
  mode_e                 mode_q;
  logic                  mask_q;
  logic [VEC_W-1:0]      vec_q;
  logic [PSC_CODE_W-1:0] shift;
  logic                  tick;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  dct_regs #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_wr   (load_wr),
    .prediv_wr (prediv_wr),
    .ctl_wr    (ctl_wr),
    .wdata     (wdata),
    .load_q    (load_val),
    .prediv_q  (prediv_q),
    .mode_q    (mode_q),
    .mask_q    (mask_q),
    .vec_q     (vec_q)
  );

  assign shift = psc_shift(prediv_q);

  dct_prescaler #(.SHIFT_W(PSC_CODE_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clear (load_wr),
    .shift (shift),
    .tick  (tick)
  );

  dct_counter #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (load_wr),
    .load_data  (wdata),
    .reload     (load_val),
    .tick       (tick),
    .mode       (mode_q),
    .masked     (mask_q),
    .vec        (vec_q),
    .count_q    (count_now),
    .fire_q     (irq_fire),
    .fire_vec_q (irq_vec)
  );

  assign prediv_val = prediv_q;

  always_comb begin
    ctl_val                   = '0;
    ctl_val[CTL_PERIODIC_BIT] = (mode_q == MODE_PERIODIC);
    ctl_val[CTL_MASK_BIT]     = mask_q;
    ctl_val[VEC_W-1:0]        = vec_q;
  end

endmodule

// File: tb/sim_dctimer.sv
module sim_dctimer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_wr = 1'b0;
  logic        prediv_wr = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] count_now;
  logic [31:0] load_val;
  logic [3:0]  prediv_val;
  logic [31:0] ctl_val;
  logic        irq_fire;
  logic [7:0]  irq_vec;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dctimer u0 (
    .clk(clk), .rst_n(rst_n), .load_wr(load_wr), .prediv_wr(prediv_wr),
    .ctl_wr(ctl_wr), .wdata(wdata), .count_now(count_now), .load_val(load_val),
    .prediv_val(prediv_val), .ctl_val(ctl_val), .irq_fire(irq_fire), .irq_vec(irq_vec)
  );

  typedef struct packed {
    logic [3:0] raw;
    logic [7:0] div;
    logic [7:0] n;
    logic       per;
    logic [7:0] vec;
  } row_t;

  // raw prescaler write, expected divisor, start count, periodic, vector
  localparam row_t TBL [9] = '{
    '{4'hB, 8'd1,   8'd3, 1'b0, 8'h21},
    '{4'hF, 8'd1,   8'd5, 1'b1, 8'h33},
    '{4'h0, 8'd2,   8'd2, 1'b0, 8'h40},
    '{4'h1, 8'd4,   8'd1, 1'b1, 8'h5A},
    '{4'h8, 8'd32,  8'd0, 1'b0, 8'h66},
    '{4'h3, 8'd16,  8'd2, 1'b1, 8'h7F},
    '{4'hA, 8'd128, 8'd1, 1'b0, 8'h81},
    '{4'h9, 8'd64,  8'd0, 1'b1, 8'hFE},
    '{4'h2, 8'd8,   8'd4, 1'b1, 8'h01}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [31:0] d);
    @(negedge clk);
    wdata = d;
    load_wr = (which == 0);
    prediv_wr = (which == 1);
    ctl_wr = (which == 2);
    @(negedge clk);
    load_wr = 1'b0;
    prediv_wr = 1'b0;
    ctl_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pulses;
    int first_t;
    logic [31:0] cnt_at_t;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(count_now == 0, "R1 count", count_now, 0);
    chk(load_val == 0, "R1 load", load_val, 0);
    chk(prediv_val == 0, "R1 prediv", {28'd0, prediv_val}, 0);
    chk(ctl_val == 32'h00010000, "R1 ctl", ctl_val, 32'h00010000);
    chk(!irq_fire && irq_vec == 0, "R1 irq", {23'd0, irq_fire, irq_vec}, 0);

    // R11 idle before any load
    wr(2, 32'h00020010);
    pulses = 0;
    for (int j = 0; j < 200; j++) begin
      @(negedge clk);
      if (irq_fire) pulses++;
    end
    chk(pulses == 0, "R11 idle pulses", pulses, 0);
    chk(count_now == 0, "R11 idle count", count_now, 0);

    // R2 / R3 field keeping
    wr(1, 32'hFFFFFFFF);
    chk(prediv_val == 4'hB, "R2 prediv keep", {28'd0, prediv_val}, 32'hB);
    wr(2, 32'hFFFFFFFF);
    chk(ctl_val == 32'h000300FF, "R3 ctl keep", ctl_val, 32'h000300FF);

    // Table walk: R4 R5 R6 R7 R8 R10
    for (int e = 0; e < 9; e++) begin
      int t;
      t = (int'(TBL[e].n) + 1) * int'(TBL[e].div);
      wr(1, {28'd0, TBL[e].raw});
      chk(prediv_val == (TBL[e].raw & 4'hB), "R2 prediv row", {28'd0, prediv_val}, {28'd0, TBL[e].raw & 4'hB});
      wr(2, {14'd0, TBL[e].per, 1'b0, 8'd0, TBL[e].vec});
      wr(0, {24'd0, TBL[e].n});
      chk(count_now == {24'd0, TBL[e].n}, "R5 load value", count_now, {24'd0, TBL[e].n});
      pulses = 0;
      first_t = -1;
      cnt_at_t = '0;
      for (int j = 1; j <= 2 * t + 2; j++) begin
        @(negedge clk);
        if (irq_fire) begin
          pulses++;
          if (first_t < 0) begin
            first_t = j;
            chk(irq_vec == TBL[e].vec, "R10 vector", {24'd0, irq_vec}, {24'd0, TBL[e].vec});
          end
        end
        if (j == int'(TBL[e].div) && TBL[e].n != 0)
          chk(count_now == {24'd0, TBL[e].n} - 1, "R4 first tick", count_now, {24'd0, TBL[e].n} - 1);
        if (j == t) cnt_at_t = count_now;
        if (j == t + 1)
          chk(!irq_fire && irq_vec == 0, "R10 single cycle", {23'd0, irq_fire, irq_vec}, 0);
      end
      if (TBL[e].per) begin
        chk(first_t == t, "R8 first period", first_t, t);
        chk(pulses == 2, "R8 pulse count", pulses, 2);
        chk(cnt_at_t == {24'd0, TBL[e].n}, "R8 reload", cnt_at_t, {24'd0, TBL[e].n});
      end else begin
        chk(first_t == t, "R7 oneshot time", first_t, t);
        chk(pulses == 1, "R7 oneshot once", pulses, 1);
        chk(cnt_at_t == 0 && count_now == 0, "R6 hold zero", count_now, 0);
      end
    end

    // R9 masked periodic keeps counting, no pulse
    wr(1, 32'hB);
    wr(2, 32'h00030044);
    wr(0, 32'd2);
    pulses = 0;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (irq_fire) pulses++;
      if (j == 3) chk(count_now == 2, "R9 masked reload", count_now, 2);
    end
    chk(pulses == 0, "R9 masked periodic", pulses, 0);

    // R9 masked one-shot end is used up
    wr(2, 32'h00010044);
    wr(0, 32'd2);
    repeat (6) @(negedge clk);
    wr(2, 32'h00000044);
    pulses = 0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (irq_fire) pulses++;
    end
    chk(pulses == 0, "R9 shot used", pulses, 0);
    chk(count_now == 0, "R9 count rests", count_now, 0);

    // R5 restart mid-count
    wr(2, 32'h00020055);
    wr(0, 32'd5);
    repeat (3) @(negedge clk);
    chk(count_now == 2, "R4 mid count", count_now, 2);
    wr(0, 32'd5);
    chk(count_now == 5, "R5 restart value", count_now, 5);
    first_t = -1;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      if (irq_fire && first_t < 0) begin
        first_t = j;
        chk(irq_vec == 8'h55, "R10 restart vector", {24'd0, irq_vec}, 32'h55);
      end
    end
    chk(first_t == 6, "R5 restart timing", first_t, 6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule